// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is the datapath for the prefixed bit-operation group of an 8-bit processor core. It covers eight rotate and shift variants and three single-bit operations: test, clear and set. The result byte is produced combinationally from the operand, so the core can write it back in the same cycle it presents the operand. The new flag byte is captured into an internal flag register on the clock edge that follows a strobed operation.

The surrounding core supplies several inputs. One is the operand byte from a register or from memory. Another is a two-bit group code, where 0 means rotate/shift, 1 means bit test, 2 means bit clear and 3 means bit set. A three-bit selector chooses either the shift variant or the bit number. The core also supplies the current carry, a flag that marks the operand as coming from memory, and the high byte of the hidden internal address register. The core does its own register-file access, memory cycles and timing.

Top module: `cb_unit`

## Requirements
- R1: With group 0, selector values 0..7 give: 0 rotate left circular, 1 rotate right circular, 4 shift left with 0 into bit 0, 5 shift right keeping bit 7, 6 shift left with 1 into bit 0, 7 shift right with 0 into bit 7.
- R2: Selector 2 (rotate left through carry) puts `carry_in` into bit 0, and selector 3 (rotate right through carry) puts `carry_in` into bit 7.
- R3: For every rotate or shift, the new carry (flag bit 0) is the bit shifted out of the operand.
- R4: The flag byte is laid out as bit 7 sign, 6 zero, 5 copy-Y, 4 half-carry, 3 copy-X, 2 parity/overflow, 1 subtract, 0 carry. After a rotate or shift, half-carry and subtract are 0. Sign, copy-Y and copy-X are result bits 7, 5 and 3. Zero is set for a zero result, and parity/overflow is 1 when the result has an even number of ones.
- R5: A bit test (group 1) sets both zero and parity/overflow to the inverse of the tested bit. It sets half-carry to 1, clears subtract, and copies `carry_in` to carry. The result output equals the operand.
- R6: A bit test sets sign only when the selector is 7 and operand bit 7 is 1. In every other case sign is 0.
- R7: A bit test with `mem_operand` low takes copy-Y/copy-X from operand bits 5/3. With `mem_operand` high it takes them from bits 5/3 of `addr_hi`.
- R8: Group 2 clears operand bit `sel`, and group 3 sets it. All other bits pass through unchanged.
- R9: `flag_we` is high only when `op_valid` is high and the group is 0 or 1. Group 2 and group 3 leave `flags` unchanged.
- R10: Reset clears `flags` to 0x00. `flags` takes the new flag byte on the clock edge where `op_valid` and `flag_we` are high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe; allows flag capture |
| group | input | 2 | 0 rotate/shift, 1 test, 2 clear, 3 set |
| sel | input | 3 | Shift variant or bit number |
| operand | input | 8 | Input byte |
| carry_in | input | 1 | Current carry flag |
| mem_operand | input | 1 | Operand comes from memory |
| addr_hi | input | 8 | High byte of hidden address register |
| result | output | 8 | Combinational result byte |
| flags | output | 8 | Registered flag byte |
| flag_we | output | 1 | Flag update in this cycle |

## Verification
Two things can happen in the same cycle. One is the combinational result of an operation. The other is the flag register either capturing that operation's flags or holding flags from an earlier operation. The bench provokes both cases by issuing bit clear/set directly after flag-writing operations. It then checks that the result changes in that cycle while `flags` still carries the earlier operation's byte. For memory bit tests, zero comes from the operand and copy-X/Y come from `addr_hi` in the same cycle. The bench judges this with operands and address bytes whose bits 5/3 differ.

// File: rtl/cb_unit.sv
module cb_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   group,
  input  logic [2:0]   sel,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  input  logic         mem_operand,
  input  logic [W-1:0] addr_hi,
  output logic [W-1:0] result,
  output logic [W-1:0] flags,
  output logic         flag_we
);
  localparam logic [1:0] G_SHIFT = 2'd0;
  localparam logic [1:0] G_TEST  = 2'd1;
  localparam logic [1:0] G_CLR   = 2'd2;
  localparam logic [1:0] G_SET   = 2'd3;

  logic [W-1:0] sh_res, mask, xy_src, flags_next;
  logic         sh_cy, tbit;

  always_comb begin
    case (sel)
      3'd0: {sh_cy, sh_res} = {operand[7], operand[6:0], operand[7]};
      3'd1: {sh_cy, sh_res} = {operand[0], operand[0], operand[7:1]};
      3'd2: {sh_cy, sh_res} = {operand[7], operand[6:0], carry_in};
      3'd3: {sh_cy, sh_res} = {operand[0], carry_in, operand[7:1]};
      3'd4: {sh_cy, sh_res} = {operand[7], operand[6:0], 1'b0};
      3'd5: {sh_cy, sh_res} = {operand[0], operand[7], operand[7:1]};
      3'd6: {sh_cy, sh_res} = {operand[7], operand[6:0], 1'b1};
      default: {sh_cy, sh_res} = {operand[0], 1'b0, operand[7:1]};
    endcase
  end

  assign mask   = W'(1) << sel;
  assign tbit   = operand[sel];
  assign xy_src = mem_operand ? addr_hi : operand;

  always_comb begin
    case (group)
      G_SHIFT: result = sh_res;
      G_TEST:  result = operand;
      G_CLR:   result = operand & ~mask;
      default: result = operand | mask;
    endcase
  end

  always_comb begin
    if (group == G_SHIFT)
      flags_next = {sh_res[7], sh_res == '0, sh_res[5], 1'b0,
                    sh_res[3], ~^sh_res, 1'b0, sh_cy};
    else
      flags_next = {(sel == 3'd7) & tbit, ~tbit, xy_src[5], 1'b1,
                    xy_src[3], ~tbit, 1'b0, carry_in};
  end

  assign flag_we = op_valid & ~group[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_we) flags <= flags_next;
  end

  AST_CLRSET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (group == G_CLR || group == G_SET)) |=> $stable(flags)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags)); // R10
  AST_SHIFT_HN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && group == G_SHIFT) |=> (flags[4] == 1'b0 && flags[1] == 1'b0)); // R4
  AST_TEST_ZPV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && group == G_TEST) |=> (flags[6] == flags[2] && flags[4])); // R5
  AST_TEST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (group == G_TEST) |-> result == operand); // R5
  AST_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (group == G_CLR) |-> result[sel] == 1'b0); // R8
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (group == G_SET) |-> result[sel] == 1'b1); // R8
  AST_TEST_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && group == G_TEST && sel != 3'd7) |=> !flags[7]); // R6
endmodule

// File: tb/cb_unit_tb.sv
module cb_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, carry_in = 1'b0, mem_operand = 1'b0;
  logic [1:0] group = '0;
  logic [2:0] sel = '0;
  logic [7:0] operand = '0, addr_hi = '0;
  logic [7:0] result, flags;
  logic flag_we;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_flags = '0;

  always #4 clk = ~clk;

  cb_unit u_dut (.clk, .rst_n, .op_valid, .group, .sel, .operand, .carry_in,
                 .mem_operand, .addr_hi, .result, .flags, .flag_we);

  // {group, sel, carry_in, mem, addr_hi, operand, expected result}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h81, 8'h03},  // R1 rlc
    {2'd0, 3'd1, 1'b0, 1'b0, 8'h00, 8'h01, 8'h80},  // R1 rrc
    {2'd0, 3'd2, 1'b1, 1'b0, 8'h00, 8'h80, 8'h01},  // R2 rl
    {2'd0, 3'd3, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00},  // R2 rr zero
    {2'd0, 3'd3, 1'b1, 1'b0, 8'h00, 8'h02, 8'h81},  // R2 rr cin
    {2'd2, 3'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFE},  // R8 clr after shift
    {2'd0, 3'd4, 1'b1, 1'b0, 8'h00, 8'hC1, 8'h82},  // R1 sla
    {2'd0, 3'd5, 1'b0, 1'b0, 8'h00, 8'h81, 8'hC0},  // R1 sra
    {2'd0, 3'd6, 1'b0, 1'b0, 8'h00, 8'h40, 8'h81},  // R1 sll
    {2'd0, 3'd7, 1'b1, 1'b0, 8'h00, 8'h81, 8'h40},  // R1 srl
    {2'd1, 3'd7, 1'b1, 1'b0, 8'h00, 8'h80, 8'h80},  // R6 test b7 set
    {2'd3, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 8'h80},  // R8 set
    {2'd1, 3'd3, 1'b0, 1'b1, 8'h28, 8'h00, 8'h00},  // R7 mem test
    {2'd1, 3'd5, 1'b0, 1'b0, 8'h00, 8'h28, 8'h28},  // R7 reg test
    {2'd2, 3'd5, 1'b0, 1'b0, 8'h00, 8'h20, 8'h00},  // R8 clr
    {2'd3, 3'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h04}   // R8 set
  };

  function automatic logic [7:0] model_flags(logic [1:0] g, logic [2:0] s, logic ci,
      logic m, logic [7:0] ah, logic [7:0] op, logic [7:0] r);
    logic [7:0] f = '0;
    int ones = 0;
    logic b;
    if (g == 2'd0) begin
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      f[7] = r[7]; f[6] = (r == 8'h00); f[5] = r[5]; f[3] = r[3];
      f[2] = (ones % 2 == 0);
      f[0] = (s == 3'd0 || s == 3'd2 || s == 3'd4 || s == 3'd6) ? op[7] : op[0];
    end else begin
      b = op[s];
      f[7] = (s == 3'd7) && b; f[6] = !b; f[2] = !b; f[4] = 1'b1; f[0] = ci;
      f[5] = m ? ah[5] : op[5]; f[3] = m ? ah[3] : op[3];
    end
    return f;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset flags", flags, 8'h00);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {group, sel, carry_in, mem_operand, addr_hi, operand} = VEC[v][37:8];
      op_valid = 1'b1;
      #1;
      check(group[1] ? "R9" : "R5", "flag_we", {7'd0, flag_we}, {7'd0, !group[1]});
      check(group == 0 ? "R1" : (group == 1 ? "R5" : "R8"), "result", result, VEC[v][7:0]);
      check("R10", "flags before edge", flags, exp_flags);
      if (!group[1])
        exp_flags = model_flags(group, sel, carry_in, mem_operand, addr_hi, operand, VEC[v][7:0]);
      @(negedge clk);
      check(group == 0 ? "R3" : (group == 1 ? "R7" : "R9"), "flags", flags, exp_flags);
    end
    // R10: idle shift leaves flags alone
    @(negedge clk);
    op_valid = 1'b0; group = 2'd0; sel = 3'd0; operand = 8'h00;
    #1 check("R9", "flag_we idle", {7'd0, flag_we}, 8'h00);
    @(negedge clk);
    check("R10", "hold when idle", flags, exp_flags);
    // R4: parity odd, sign clear
    op_valid = 1'b1; group = 2'd0; sel = 3'd7; operand = 8'h0E; carry_in = 1'b0;
    @(negedge clk);
    check("R4", "srl 0E flags", flags, 8'h00);
    // R5: carry copied through test with bit set
    group = 2'd1; sel = 3'd0; operand = 8'h01; carry_in = 1'b1;
    @(negedge clk);
    check("R5", "test bit0 set", flags, 8'h11);
    // R6: test bit 7 clear
    sel = 3'd7; operand = 8'h7F; carry_in = 1'b0; mem_operand = 1'b0;
    @(negedge clk);
    check("R6", "test b7 clear", flags, 8'h7C);
    // R10: reset mid-run
    op_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset again", flags, 8'h00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule